// File: doc/BRIEF.md
# Tape Record Stream Framer

This block moves data between logical tape records and the flat byte image of a tape held in sequential storage. The encoder takes a command that gives a record length, pulls exactly that many payload bytes and sends the framed image downstream. In that image a 32-bit length field comes first, the payload follows, then a zero filler byte when the length is odd, and finally a copy of the length field. A command with length zero produces a file mark, which is a single length field of zero with no closing copy.

The decoder takes one command per tape item, either to read it or to skip it. It parses the incoming image and delivers the payload bytes with a last-byte flag. It then reports what it found as a one-cycle event: normal record, file mark, logical end of tape (a second file mark directly after a first), trailer mismatch, or a length above the configured maximum. Every byte port uses a valid/ready handshake.

The encoder states are W_IDLE, W_HEAD, W_BODY, W_FILL and W_TAIL. W_IDLE goes to W_HEAD when a command is accepted. W_HEAD goes to W_IDLE after four bytes if the length is zero, otherwise to W_BODY. W_BODY goes to W_FILL after the last byte of an odd-length record, otherwise to W_TAIL. W_FILL goes to W_TAIL, and W_TAIL goes to W_IDLE after four bytes. The decoder states are R_IDLE, R_HEAD, R_EVAL, R_BODY, R_FILL, R_TAIL and R_CHECK. R_IDLE goes to R_HEAD when a command is accepted, and R_HEAD goes to R_EVAL after four bytes. R_EVAL goes to R_IDLE on a zero length or an oversize length, otherwise to R_BODY. R_BODY goes to R_FILL or R_TAIL on the same odd/even rule as the encoder. R_FILL goes to R_TAIL, R_TAIL goes to R_CHECK after four bytes, and R_CHECK goes back to R_IDLE.

Top module: `tape_rec_framer`

## Requirements
- R1: Encoder: before the payload of a nonzero-length record, four bytes carry the length as a 32-bit value, least significant byte first, followed by the payload bytes unchanged and in order.
- R2: Encoder: after the payload (and filler, if any), the same four length bytes are repeated in the same byte order.
- R3: Encoder: for an odd length, exactly one byte of value 0x00 follows the last payload byte; the length fields do not count it.
- R4: Encoder: a command of length 0 produces exactly four 0x00 bytes and nothing else.
- R5: Decoder, read command: exactly the header count of payload bytes is delivered in order, with the last flag set only on the final one. A filler byte is consumed and never delivered, and the event is a record event with the length output equal to the header value.
- R6: Decoder, skip command (skip=1): the record is consumed without any byte delivered, and a record event with the correct length still follows.
- R7: Decoder: a zero header gives a file mark event, unless the previous item was also a file mark.
- R8: Decoder: a zero header directly after a file mark gives an end-of-tape event instead of a file mark event.
- R9: Decoder: a trailer that differs from the header gives a format-error event instead of a record event, and the next item is parsed normally.
- R10: Decoder: a header above MAX_LEN gives an invalid-length event right after the header, delivers no payload and returns to idle.
- R11: The decoder events are single-cycle pulses, and at most one of them is active in any cycle.
- R12: Each port holds its byte stable while valid is high and ready is low. A command is accepted only when idle, so command ready drops in the cycle after an acceptance.
- R13: After reset both sides are idle: both command readies are high, and no output valid or event is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wc_valid | input | 1 | Encoder command valid |
| wc_ready | output | 1 | Encoder idle, command accepted |
| wc_len | input | LEN_W | Record length, 0 writes a file mark |
| wd_data | input | 8 | Payload byte to encode |
| wd_valid | input | 1 | Payload byte valid |
| wd_ready | output | 1 | Payload byte taken |
| ws_data | output | 8 | Framed image byte out |
| ws_valid | output | 1 | Framed byte valid |
| ws_ready | input | 1 | Storage accepts framed byte |
| rc_valid | input | 1 | Decoder command valid |
| rc_ready | output | 1 | Decoder idle, command accepted |
| rc_skip | input | 1 | 1 = skip the item, 0 = read it |
| rs_data | input | 8 | Framed image byte in |
| rs_valid | input | 1 | Image byte valid |
| rs_ready | output | 1 | Image byte consumed |
| rd_data | output | 8 | Decoded payload byte |
| rd_valid | output | 1 | Payload byte valid |
| rd_ready | input | 1 | Consumer takes payload byte |
| rd_last | output | 1 | Final payload byte of the record |
| rd_len | output | LEN_W | Length of the last record header |
| ev_rec | output | 1 | Record completed with matching trailer |
| ev_mark | output | 1 | File mark seen |
| ev_eot | output | 1 | Second consecutive file mark |
| ev_fmt_err | output | 1 | Trailer mismatch |
| ev_len_err | output | 1 | Header above MAX_LEN |

## Verification
The assertions check on every cycle that the events are one-hot single pulses and that the self-generated framing bytes are held under back-pressure. They also check that commands are taken only from idle, that nothing is delivered in the cycle after a last byte, and that a reported length never exceeds MAX_LEN. Only the bench scenarios can show the byte order of the length fields, the placement and value of the filler byte, the end-of-tape rule across a record in between, and that skipped records deliver nothing. The bench compares every handshake against a queue model with back-pressure on both sides.

// File: rtl/tape_frm_pkg.sv
package tape_frm_pkg;
    localparam int FIELD_BYTES = 4;
    localparam int FIELD_W     = 8 * FIELD_BYTES;
    localparam int IDX_W       = $clog2(FIELD_BYTES);

    typedef enum logic [2:0] {
        W_IDLE, W_HEAD, W_BODY, W_FILL, W_TAIL
    } wr_state_e;

    typedef enum logic [2:0] {
        R_IDLE, R_HEAD, R_EVAL, R_BODY, R_FILL, R_TAIL, R_CHECK
    } rd_state_e;
endpackage

// File: rtl/tape_frm_writer.sv
module tape_frm_writer
    import tape_frm_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [7:0]       out_data,
    output logic             out_valid,
    input  logic             out_ready
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FIELD_BYTES - 1);

    wr_state_e          state, nxt;
    logic [FIELD_W-1:0] len_q;
    logic [LEN_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= W_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
            cnt   <= '0;
            idx   <= '0;
        end else begin
            if (state == W_IDLE && cmd_valid) begin
                len_q <= {{(FIELD_W-LEN_W){1'b0}}, cmd_len};
                cnt   <= cmd_len;
                idx   <= '0;
            end
            if ((state == W_HEAD || state == W_TAIL) && out_ready)
                idx <= idx + 1'b1;
            if (state == W_BODY && in_valid && out_ready)
                cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        nxt       = state;
        cmd_ready = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = 8'h00;
        unique case (state)
            W_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) nxt = W_HEAD;
            end
            W_HEAD: begin
                out_valid = 1'b1;
                out_data  = len_q[8*idx +: 8];
                if (out_ready && idx == IDX_LAST)
                    nxt = (len_q == '0) ? W_IDLE : W_BODY;
            end
            W_BODY: begin
                out_valid = in_valid;
                out_data  = in_data;
                in_ready  = out_ready;
                if (in_valid && out_ready && cnt == LEN_W'(1))
                    nxt = len_q[0] ? W_FILL : W_TAIL;
            end
            W_FILL: begin
                out_valid = 1'b1;
                if (out_ready) nxt = W_TAIL;
            end
            W_TAIL: begin
                out_valid = 1'b1;
                out_data  = len_q[8*idx +: 8];
                if (out_ready && idx == IDX_LAST) nxt = W_IDLE;
            end
            default: nxt = W_IDLE;
        endcase
    end

    p_cmd_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    p_frame_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && state != W_BODY) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/tape_frm_reader.sv
module tape_frm_reader
    import tape_frm_pkg::*;
#(
    parameter int MAX_LEN = 1024,
    parameter int LEN_W   = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_skip,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [7:0]       out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_last,
    output logic [LEN_W-1:0] rec_len,
    output logic             ev_rec,
    output logic             ev_mark,
    output logic             ev_eot,
    output logic             ev_fmt,
    output logic             ev_len
);
    localparam logic [IDX_W-1:0]   IDX_LAST = IDX_W'(FIELD_BYTES - 1);
    localparam logic [FIELD_W-1:0] LEN_CAP  = FIELD_W'(MAX_LEN);

    rd_state_e          state, nxt;
    logic [FIELD_W-1:0] hdr, trl;
    logic [LEN_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx;
    logic               skip_q, mark_q, take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= R_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr <= '0; trl <= '0; cnt <= '0; idx <= '0;
            skip_q <= 1'b0; mark_q <= 1'b0; rec_len <= '0;
            ev_rec <= 1'b0; ev_mark <= 1'b0; ev_eot <= 1'b0;
            ev_fmt <= 1'b0; ev_len <= 1'b0;
        end else begin
            ev_rec <= 1'b0; ev_mark <= 1'b0; ev_eot <= 1'b0;
            ev_fmt <= 1'b0; ev_len <= 1'b0;
            unique case (state)
                R_IDLE: if (cmd_valid) begin
                    skip_q <= cmd_skip;
                    idx    <= '0;
                end
                R_HEAD: if (in_valid) begin
                    hdr <= {in_data, hdr[FIELD_W-1:8]};
                    idx <= idx + 1'b1;
                end
                R_EVAL: begin
                    if (hdr == '0) begin
                        ev_eot  <= mark_q;
                        ev_mark <= !mark_q;
                        mark_q  <= 1'b1;
                    end else if (hdr > LEN_CAP) begin
                        ev_len <= 1'b1;
                        mark_q <= 1'b0;
                    end else begin
                        rec_len <= hdr[LEN_W-1:0];
                        cnt     <= hdr[LEN_W-1:0];
                    end
                end
                R_BODY: if (take) cnt <= cnt - 1'b1;
                R_FILL: ;
                R_TAIL: if (in_valid) begin
                    trl <= {in_data, trl[FIELD_W-1:8]};
                    idx <= idx + 1'b1;
                end
                R_CHECK: begin
                    ev_rec <= (trl == hdr);
                    ev_fmt <= (trl != hdr);
                    mark_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        nxt       = state;
        cmd_ready = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = in_data;
        out_last  = 1'b0;
        take      = 1'b0;
        unique case (state)
            R_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) nxt = R_HEAD;
            end
            R_HEAD: begin
                in_ready = 1'b1;
                if (in_valid && idx == IDX_LAST) nxt = R_EVAL;
            end
            R_EVAL: nxt = (hdr == '0 || hdr > LEN_CAP) ? R_IDLE : R_BODY;
            R_BODY: begin
                out_valid = !skip_q && in_valid;
                out_last  = (cnt == LEN_W'(1));
                in_ready  = skip_q || out_ready;
                take      = in_valid && (skip_q || out_ready);
                if (take && cnt == LEN_W'(1)) nxt = hdr[0] ? R_FILL : R_TAIL;
            end
            R_FILL: begin
                in_ready = 1'b1;
                if (in_valid) nxt = R_TAIL;
            end
            R_TAIL: begin
                in_ready = 1'b1;
                if (in_valid && idx == IDX_LAST) nxt = R_CHECK;
            end
            R_CHECK: nxt = R_IDLE;
            default: nxt = R_IDLE;
        endcase
    end

    p_evt_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_rec, ev_mark, ev_eot, ev_fmt, ev_len}));

    p_evt_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rec || ev_mark || ev_eot || ev_fmt || ev_len) |=>
        !(ev_rec || ev_mark || ev_eot || ev_fmt || ev_len));

    p_last_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);

    p_len_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rec |-> (rec_len <= LEN_W'(MAX_LEN)));

    p_cmd_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);
endmodule

// File: rtl/tape_rec_framer.sv
module tape_rec_framer #(
    parameter  int MAX_LEN = 1024,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wc_valid,
    output logic             wc_ready,
    input  logic [LEN_W-1:0] wc_len,
    input  logic [7:0]       wd_data,
    input  logic             wd_valid,
    output logic             wd_ready,
    output logic [7:0]       ws_data,
    output logic             ws_valid,
    input  logic             ws_ready,
    input  logic             rc_valid,
    output logic             rc_ready,
    input  logic             rc_skip,
    input  logic [7:0]       rs_data,
    input  logic             rs_valid,
    output logic             rs_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic             rd_last,
    output logic [LEN_W-1:0] rd_len,
    output logic             ev_rec,
    output logic             ev_mark,
    output logic             ev_eot,
    output logic             ev_fmt_err,
    output logic             ev_len_err
);
    tape_frm_writer #(.LEN_W(LEN_W)) u_enc (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(wc_valid), .cmd_ready(wc_ready), .cmd_len(wc_len),
        .in_data(wd_data), .in_valid(wd_valid), .in_ready(wd_ready),
        .out_data(ws_data), .out_valid(ws_valid), .out_ready(ws_ready)
    );

    tape_frm_reader #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(rc_valid), .cmd_ready(rc_ready), .cmd_skip(rc_skip),
        .in_data(rs_data), .in_valid(rs_valid), .in_ready(rs_ready),
        .out_data(rd_data), .out_valid(rd_valid), .out_ready(rd_ready),
        .out_last(rd_last), .rec_len(rd_len),
        .ev_rec(ev_rec), .ev_mark(ev_mark), .ev_eot(ev_eot),
        .ev_fmt(ev_fmt_err), .ev_len(ev_len_err)
    );
endmodule

// File: tb/tape_rec_framer_tb_top.sv
module tape_rec_framer_tb_top;
    localparam int MAX_LEN = 1024;
    localparam int LW = $clog2(MAX_LEN + 1);
    localparam int EV_REC = 1, EV_MARK = 2, EV_EOT = 3, EV_FMT = 4, EV_LEN = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wc_valid = 0, wc_ready, wd_valid = 0, wd_ready, ws_valid, ws_ready = 0;
    logic [LW-1:0] wc_len = '0, rd_len;
    logic [7:0] wd_data = 0, ws_data, rs_data = 0, rd_data;
    logic rc_valid = 0, rc_ready, rc_skip = 0, rs_valid = 0, rs_ready;
    logic rd_valid, rd_ready = 0, rd_last;
    logic ev_rec, ev_mark, ev_eot, ev_fmt_err, ev_len_err;

    always #10 clk = ~clk;

    tape_rec_framer #(.MAX_LEN(MAX_LEN)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wc_valid(wc_valid), .wc_ready(wc_ready), .wc_len(wc_len),
        .wd_data(wd_data), .wd_valid(wd_valid), .wd_ready(wd_ready),
        .ws_data(ws_data), .ws_valid(ws_valid), .ws_ready(ws_ready),
        .rc_valid(rc_valid), .rc_ready(rc_ready), .rc_skip(rc_skip),
        .rs_data(rs_data), .rs_valid(rs_valid), .rs_ready(rs_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_last(rd_last), .rd_len(rd_len),
        .ev_rec(ev_rec), .ev_mark(ev_mark), .ev_eot(ev_eot),
        .ev_fmt_err(ev_fmt_err), .ev_len_err(ev_len_err)
    );

    int total = 0, bad = 0, cyc = 0;
    int wcq[$], wdq[$], exp_ws[$], rcq[$], rsq[$], exp_rd[$], exp_ev[$], exp_len[$];
    string ws_tag[$], rd_tag[$], ev_tag[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_field(input int v, input bit to_ws, input string tag);
        for (int i = 0; i < 4; i++) begin
            if (to_ws) begin exp_ws.push_back((v >> (8*i)) & 255); ws_tag.push_back(tag); end
            else rsq.push_back((v >> (8*i)) & 255);
        end
    endtask

    task automatic add_wr(input int n, input int seed);
        wcq.push_back(n);
        push_field(n, 1'b1, (n == 0) ? "R4" : "R1");
        if (n == 0) return;
        for (int i = 0; i < n; i++) begin
            wdq.push_back((seed + i*37) & 255);
            exp_ws.push_back((seed + i*37) & 255); ws_tag.push_back("R1");
        end
        if (n % 2 == 1) begin exp_ws.push_back(0); ws_tag.push_back("R3"); end
        push_field(n, 1'b1, "R2");
    endtask

    task automatic add_rd(input int n, input bit skip, input int seed, input int tl,
                          input int code, input string tag);
        rcq.push_back(skip);
        push_field(n, 1'b0, "");
        exp_ev.push_back(code); exp_len.push_back(n); ev_tag.push_back(tag);
        if (n == 0 || n > MAX_LEN) return;
        for (int i = 0; i < n; i++) begin
            rsq.push_back((seed + i*11) & 255);
            if (!skip) begin
                exp_rd.push_back(((seed + i*11) & 255) | ((i == n-1) ? 256 : 0));
                rd_tag.push_back(tag);
            end
        end
        if (n % 2 == 1) rsq.push_back(8'hA5);
        push_field(tl, 1'b0, "");
    endtask

    bit t_wc, t_wd, t_rc, t_rs, ws_stall, rd_stall;
    logic [7:0] ws_prev, rd_prev;

    initial begin
        repeat (3) @(negedge clk);
        chk(wc_ready && rc_ready, "R13", {wc_ready, rc_ready}, 3);
        chk(!ws_valid && !rd_valid, "R13", {ws_valid, rd_valid}, 0);
        chk({ev_rec, ev_mark, ev_eot, ev_fmt_err, ev_len_err} == 0, "R13",
            {ev_rec, ev_mark, ev_eot, ev_fmt_err, ev_len_err}, 0);
        rst_n = 1'b1;

        add_wr(5, 8'h10); add_wr(4, 8'h80); add_wr(0, 0); add_wr(1, 8'hF0); add_wr(8, 8'h33);

        add_rd(3, 0, 8'h21, 3, EV_REC, "R5");
        add_rd(0, 0, 0, 0, EV_MARK, "R7");
        add_rd(6, 1, 8'h44, 6, EV_REC, "R6");
        add_rd(0, 0, 0, 0, EV_MARK, "R7");
        add_rd(0, 0, 0, 0, EV_EOT, "R8");
        add_rd(7, 0, 8'h90, 7, EV_REC, "R5");
        add_rd(2, 0, 8'h60, 3, EV_FMT, "R9");
        add_rd(4, 0, 8'h05, 4, EV_REC, "R9");
        add_rd(2000, 0, 0, 0, EV_LEN, "R10");

        while (1) begin
            @(negedge clk);
            cyc++;
            if (t_wc) void'(wcq.pop_front());
            if (t_wd) begin void'(wdq.pop_front()); wd_valid = 0; end
            if (t_rc) void'(rcq.pop_front());
            if (t_rs) void'(rsq.pop_front());
            wc_valid = (wcq.size() > 0);
            wc_len   = (wcq.size() > 0) ? LW'(wcq[0]) : '0;
            if (!wd_valid && wdq.size() > 0 && (cyc % 3 != 0)) begin
                wd_valid = 1; wd_data = 8'(wdq[0]);
            end
            ws_ready = (cyc % 4 != 1);
            rc_valid = (rcq.size() > 0);
            rc_skip  = (rcq.size() > 0) ? rcq[0][0] : 1'b0;
            rs_valid = (rsq.size() > 0);
            rs_data  = (rsq.size() > 0) ? 8'(rsq[0]) : 8'h00;
            rd_ready = (cyc % 5 != 2);
            #5;
            if (ws_stall) chk(ws_valid && ws_data == ws_prev, "R12", ws_data, ws_prev);
            if (rd_stall) chk(rd_valid && rd_data == rd_prev, "R12", rd_data, rd_prev);
            ws_stall = ws_valid && !ws_ready; ws_prev = ws_data;
            rd_stall = rd_valid && !rd_ready; rd_prev = rd_data;
            t_wc = wc_valid && wc_ready;
            t_wd = wd_valid && wd_ready;
            t_rc = rc_valid && rc_ready;
            t_rs = rs_valid && rs_ready;
            if (ws_valid && ws_ready) begin
                if (exp_ws.size() == 0) chk(0, "R4", ws_data, -1);
                else begin
                    chk(ws_data == exp_ws[0][7:0], ws_tag[0], ws_data, exp_ws[0]);
                    void'(exp_ws.pop_front()); void'(ws_tag.pop_front());
                end
            end
            if (rd_valid && rd_ready) begin
                if (exp_rd.size() == 0) chk(0, "R6", {rd_last, rd_data}, -1);
                else begin
                    chk({rd_last, rd_data} == exp_rd[0][8:0], rd_tag[0], {rd_last, rd_data}, exp_rd[0]);
                    void'(exp_rd.pop_front()); void'(rd_tag.pop_front());
                end
            end
            if (ev_rec || ev_mark || ev_eot || ev_fmt_err || ev_len_err) begin
                int code;
                code = ev_rec ? EV_REC : ev_mark ? EV_MARK : ev_eot ? EV_EOT :
                       ev_fmt_err ? EV_FMT : EV_LEN;
                chk($countones({ev_rec, ev_mark, ev_eot, ev_fmt_err, ev_len_err}) == 1,
                    "R11", {ev_rec, ev_mark, ev_eot, ev_fmt_err, ev_len_err}, 1);
                if (exp_ev.size() == 0) chk(0, "R11", code, 0);
                else begin
                    chk(code == exp_ev[0], ev_tag[0], code, exp_ev[0]);
                    if (code == EV_REC) chk(int'(rd_len) == exp_len[0], ev_tag[0], rd_len, exp_len[0]);
                    void'(exp_ev.pop_front()); void'(exp_len.pop_front()); void'(ev_tag.pop_front());
                end
            end
            if (wcq.size() == 0 && wdq.size() == 0 && exp_ws.size() == 0 && rcq.size() == 0 &&
                rsq.size() == 0 && exp_rd.size() == 0 && exp_ev.size() == 0 && wc_ready && rc_ready)
                break;
            if (cyc > 5000) begin
                chk(0, "watchdog", cyc, 5000);
                break;
            end
        end
        chk(exp_ws.size() + exp_rd.size() + exp_ev.size() == 0, "R10",
            exp_ws.size() + exp_rd.size() + exp_ev.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule